// File: doc/BRIEF.md
# Banked Video Memory Mapping Controller

This block owns four equally sized video memory banks and decides, from one 8-bit control byte per bank, where each bank shows up. Three client address spaces can reach bank contents through a single access port: a flat CPU view, where every bank sits at its own fixed window; a background region of 32 slots; and an object region of 16 slots. Each slot of a region keeps a mask of the banks placed there. Several banks may share a slot. A read from such a slot returns the bitwise OR of the words held by those banks, and a write updates all of them. Banks can also be assigned to texture slots, to one of two auxiliary-processor windows, or to the second engine's background or object area. For these assignments the block publishes only the resulting bank masks. It does not route data to them.

Control writes pass through a small state machine with three states: `CS_IDLE`, `CS_UNMAP` and `CS_MAP`. In `CS_IDLE` a control write is accepted. If the byte differs from the stored one, the path is `CS_IDLE -> CS_UNMAP`. `CS_UNMAP` removes the bank's old footprint from every table, and the path continues `CS_UNMAP -> CS_MAP`. `CS_MAP` adds the new footprint, and the path returns `CS_MAP -> CS_IDLE`. A byte equal to the stored one takes the path `CS_IDLE -> CS_IDLE` and leaves the tables unchanged. The slot size is a parameter. With the defaults, each slot holds 16 words of 32 bits so that the banks stay small. A full-size build sets `WORD_AW` to 12.

Top module: `vram_bank_router`

## Requirements
- R1: After reset, every control byte is 0, no bank is mapped anywhere, all published masks and both status bits are 0, `ctl_ready` is 1, and every read returns 0.
- R2: Control byte bit 7 enables the bank, and a disabled bank maps nowhere. Bits 4:3 are the offset. Banks 0 and 1 decode the target from bits 1:0 and ignore bit 2. Banks 2 and 3 decode the target from bits 2:0.
- R3: Target 0 places bank k in the CPU view. In that view, address bits [WORD_AW+4:WORD_AW+3] select the bank and bits [WORD_AW+2:0] give the bank-local word. When bit [WORD_AW+5] is 1 the address falls in a gap: reads return 0 and writes are dropped.
- R4: Target 1 maps the bank to background slots offset*8 through offset*8+7. The background slot is address bits [WORD_AW+4:WORD_AW] (`acc_space`=1). The bank-local word is bits [WORD_AW+2:0]. Bit [WORD_AW+5] is ignored, so the region mirrors.
- R5: Target 2 on bank 0 or 1 maps the bank to object slots (offset&1)*8 through (offset&1)*8+7. The object slot is bits [WORD_AW+3:WORD_AW] (`acc_space`=2). Bits above that are ignored.
- R6: Target 3 sets bit offset*4+k of `tex_banks` for bank k.
- R7: Target 2 on bank 2 or 3 sets bit (offset&1)*4+k of `aux_banks` and sets `aux_status` bit k-2.
- R8: Every accepted control write to bank 2 or 3 clears that bank's status bit, including a write of the value already stored. A write of the stored value changes no mapping.
- R9: Target 4 on bank 2 sets `sec_bg_banks` bit 2, and target 4 on bank 3 sets `sec_obj_banks` bit 3. Targets 5 to 7 on banks 2 and 3 map nothing.
- R10: A changed control byte first removes every effect of the old byte and then applies the new one, so a location the bank has left reads 0.
- R11: When several banks share a slot, a read returns the OR of their words and a write stores the data in each of them.
- R12: A read returns its data one cycle after the request and pulses `rd_valid` for that cycle. A slot with no bank, and `acc_space`=3, read 0.
- R13: After a changed control write is accepted, `ctl_ready` is low for exactly two cycles. A write of the stored value keeps it high. A control write presented while `ctl_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_bank | input | 2 | Bank whose control byte is written |
| ctl_data | input | 8 | New control byte |
| ctl_ready | output | 1 | High when a control write can be accepted |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | 0 CPU view, 1 background, 2 object, 3 none |
| acc_addr | input | WORD_AW+6 | Address inside the chosen space |
| acc_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data, OR of the selected banks |
| tex_banks | output | 16 | Texture slot masks, bit slot*4+bank |
| aux_banks | output | 8 | Auxiliary window masks, bit window*4+bank |
| sec_bg_banks | output | 4 | Banks in the second engine's background area |
| sec_obj_banks | output | 4 | Banks in the second engine's object area |
| aux_status | output | 2 | Bit 0 for bank 2 and bit 1 for bank 3 placed in an auxiliary window |

## Verification
The bench applies control writes and accesses at the falling edge. Read data is due one edge after the read request, so the bench samples it at the next falling edge. A changed control byte takes effect on the second edge after it is accepted. For that reason each control write waits at falling edges until `ctl_ready` is high again, and only then are accesses made or the published masks compared. The `ctl_ready` waveform is sampled on each of the three falling edges that follow acceptance. A write of the stored value is expected to keep `ctl_ready` high at the first of those edges.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
    localparam int NUM_BANKS      = 4;
    localparam int BANK_SLOTS     = 8;
    localparam int BG_SLOTS       = 32;
    localparam int OBJ_SLOTS      = 16;
    localparam int TEX_SLOTS      = 4;
    localparam int AUX_WINDOWS    = 2;
    localparam int BANK_IDX_W     = $clog2(NUM_BANKS);
    localparam int BG_IDX_W       = $clog2(BG_SLOTS);
    localparam int OBJ_IDX_W      = $clog2(OBJ_SLOTS);
    localparam int BANK_SLOT_W    = $clog2(BANK_SLOTS);

    typedef enum logic [1:0] {
        SP_DIRECT = 2'd0,
        SP_BG     = 2'd1,
        SP_OBJ    = 2'd2,
        SP_NONE   = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_UNMAP = 2'd1,
        CS_MAP   = 2'd2
    } ctl_state_e;

    // every table location one bank occupies for a given control byte
    typedef struct packed {
        logic                   direct;
        logic [BG_SLOTS-1:0]    bg;
        logic [OBJ_SLOTS-1:0]   obj;
        logic [TEX_SLOTS-1:0]   tex;
        logic [AUX_WINDOWS-1:0] aux;
        logic                   sec_bg;
        logic                   sec_obj;
    } footprint_t;

    function automatic footprint_t bank_footprint(input logic [BANK_IDX_W-1:0] bank,
                                                  input logic [7:0] cnt);
        footprint_t f;
        logic [1:0] ofs;
        logic [2:0] tgt;
        f   = '0;
        ofs = cnt[4:3];
        // banks 2 and 3 use a three-bit target field, banks 0 and 1 a two-bit one
        tgt = bank[1] ? cnt[2:0] : {1'b0, cnt[1:0]};
        if (cnt[7]) begin
            case (tgt)
                3'd0: f.direct = 1'b1;
                3'd1: f.bg = BG_SLOTS'({BANK_SLOTS{1'b1}}) << {ofs, 3'b000};
                3'd2: begin
                    if (bank[1]) f.aux[ofs[0]] = 1'b1;
                    else         f.obj = OBJ_SLOTS'({BANK_SLOTS{1'b1}}) << {ofs[0], 3'b000};
                end
                3'd3: f.tex[ofs] = 1'b1;
                3'd4: begin
                    if (bank[1]) begin
                        if (bank[0]) f.sec_obj = 1'b1;
                        else         f.sec_bg  = 1'b1;
                    end
                end
                default: f = '0;
            endcase
        end
        return f;
    endfunction
endpackage

// File: rtl/vmap_ctl.sv
module vmap_ctl
    import vmap_pkg::*;
(
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     ctl_we,
    input  logic [BANK_IDX_W-1:0]                    ctl_bank,
    input  logic [7:0]                               ctl_data,
    output logic                                     ctl_ready,
    output logic [NUM_BANKS-1:0]                     direct_map,
    output logic [BG_SLOTS-1:0][NUM_BANKS-1:0]       bg_map,
    output logic [OBJ_SLOTS-1:0][NUM_BANKS-1:0]      obj_map,
    output logic [TEX_SLOTS-1:0][NUM_BANKS-1:0]      tex_map,
    output logic [AUX_WINDOWS-1:0][NUM_BANKS-1:0]    aux_map,
    output logic [NUM_BANKS-1:0]                     sec_bg_map,
    output logic [NUM_BANKS-1:0]                     sec_obj_map,
    output logic [1:0]                               aux_status
);
    ctl_state_e                    state, state_nx;
    logic [NUM_BANKS-1:0][7:0]     ctl_q;
    logic [BANK_IDX_W-1:0]         pend_bank;
    logic [7:0]                    old_cnt, new_cnt;
    logic                          accept, changed;
    footprint_t                    fp_old, fp_new;

    assign accept  = ctl_we && (state == CS_IDLE);
    assign changed = (ctl_data != ctl_q[ctl_bank]);
    assign fp_old  = bank_footprint(pend_bank, old_cnt);
    assign fp_new  = bank_footprint(pend_bank, new_cnt);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE:  if (accept && changed) state_nx = CS_UNMAP;
            CS_UNMAP: state_nx = CS_MAP;
            CS_MAP:   state_nx = CS_IDLE;
            default:  state_nx = CS_IDLE;
        endcase
    end

    assign ctl_ready = (state == CS_IDLE);

    // control bytes, tables and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            pend_bank   <= '0;
            old_cnt     <= '0;
            new_cnt     <= '0;
            direct_map  <= '0;
            bg_map      <= '0;
            obj_map     <= '0;
            tex_map     <= '0;
            aux_map     <= '0;
            sec_bg_map  <= '0;
            sec_obj_map <= '0;
            aux_status  <= '0;
        end else begin
            if (accept) begin
                ctl_q[ctl_bank] <= ctl_data;
                pend_bank       <= ctl_bank;
                old_cnt         <= ctl_q[ctl_bank];
                new_cnt         <= ctl_data;
                if (ctl_bank[1]) aux_status[ctl_bank[0]] <= 1'b0;
            end
            unique case (state)
                CS_UNMAP: begin
                    direct_map[pend_bank]  <= direct_map[pend_bank]  & ~fp_old.direct;
                    sec_bg_map[pend_bank]  <= sec_bg_map[pend_bank]  & ~fp_old.sec_bg;
                    sec_obj_map[pend_bank] <= sec_obj_map[pend_bank] & ~fp_old.sec_obj;
                    for (int s = 0; s < BG_SLOTS; s++)
                        bg_map[s][pend_bank] <= bg_map[s][pend_bank] & ~fp_old.bg[s];
                    for (int s = 0; s < OBJ_SLOTS; s++)
                        obj_map[s][pend_bank] <= obj_map[s][pend_bank] & ~fp_old.obj[s];
                    for (int s = 0; s < TEX_SLOTS; s++)
                        tex_map[s][pend_bank] <= tex_map[s][pend_bank] & ~fp_old.tex[s];
                    for (int s = 0; s < AUX_WINDOWS; s++)
                        aux_map[s][pend_bank] <= aux_map[s][pend_bank] & ~fp_old.aux[s];
                end
                CS_MAP: begin
                    direct_map[pend_bank]  <= direct_map[pend_bank]  | fp_new.direct;
                    sec_bg_map[pend_bank]  <= sec_bg_map[pend_bank]  | fp_new.sec_bg;
                    sec_obj_map[pend_bank] <= sec_obj_map[pend_bank] | fp_new.sec_obj;
                    for (int s = 0; s < BG_SLOTS; s++)
                        bg_map[s][pend_bank] <= bg_map[s][pend_bank] | fp_new.bg[s];
                    for (int s = 0; s < OBJ_SLOTS; s++)
                        obj_map[s][pend_bank] <= obj_map[s][pend_bank] | fp_new.obj[s];
                    for (int s = 0; s < TEX_SLOTS; s++)
                        tex_map[s][pend_bank] <= tex_map[s][pend_bank] | fp_new.tex[s];
                    for (int s = 0; s < AUX_WINDOWS; s++)
                        aux_map[s][pend_bank] <= aux_map[s][pend_bank] | fp_new.aux[s];
                    if (fp_new.aux != '0) aux_status[pend_bank[0]] <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vmap_decode.sv
module vmap_decode
    import vmap_pkg::*;
#(
    parameter int WORD_AW = 4,
    localparam int ADDR_W  = WORD_AW + 6,
    localparam int LOCAL_AW = WORD_AW + BANK_SLOT_W
) (
    input  logic [1:0]                               acc_space,
    input  logic [ADDR_W-1:0]                        acc_addr,
    input  logic [NUM_BANKS-1:0]                     direct_map,
    input  logic [BG_SLOTS-1:0][NUM_BANKS-1:0]       bg_map,
    input  logic [OBJ_SLOTS-1:0][NUM_BANKS-1:0]      obj_map,
    output logic [NUM_BANKS-1:0]                     sel,
    output logic [LOCAL_AW-1:0]                      local_addr
);
    logic                  gap;
    logic [BANK_IDX_W-1:0] dir_bank;
    logic [BG_IDX_W-1:0]   bg_slot;
    logic [OBJ_IDX_W-1:0]  obj_slot;

    assign gap        = acc_addr[WORD_AW+5];
    assign dir_bank   = acc_addr[WORD_AW+4 -: BANK_IDX_W];
    assign bg_slot    = acc_addr[WORD_AW +: BG_IDX_W];
    assign obj_slot   = acc_addr[WORD_AW +: OBJ_IDX_W];
    // the low slot bits double as the bank-local slot in every space
    assign local_addr = acc_addr[LOCAL_AW-1:0];

    always_comb begin
        sel = '0;
        unique case (space_e'(acc_space))
            SP_DIRECT: if (!gap && direct_map[dir_bank]) sel[dir_bank] = 1'b1;
            SP_BG:     sel = bg_map[bg_slot];
            SP_OBJ:    sel = obj_map[obj_slot];
            SP_NONE:   sel = '0;
            default:   sel = '0;
        endcase
    end
endmodule

// File: rtl/vmap_bank_array.sv
module vmap_bank_array
    import vmap_pkg::*;
#(
    parameter int WORD_AW = 4,
    parameter int DATA_W  = 32,
    localparam int LOCAL_AW = WORD_AW + BANK_SLOT_W,
    localparam int DEPTH    = 1 << LOCAL_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_en,
    input  logic                  acc_we,
    input  logic [NUM_BANKS-1:0]  sel,
    input  logic [LOCAL_AW-1:0]   local_addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data
);
    logic [NUM_BANKS-1:0]             sel_q;
    logic [NUM_BANKS-1:0][DATA_W-1:0] word_q;
    logic                             rd_req;

    assign rd_req = acc_en && !acc_we;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (acc_en && acc_we && sel[b]) mem[local_addr] <= wdata;
            word_q[b] <= mem[local_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            rd_valid <= 1'b0;
        end else begin
            sel_q    <= rd_req ? sel : '0;
            rd_valid <= rd_req;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (sel_q[b]) rd_data = rd_data | word_q[b];
    end
endmodule

// File: rtl/vram_bank_router.sv
module vram_bank_router
    import vmap_pkg::*;
#(
    parameter int WORD_AW = 4,
    parameter int DATA_W  = 32,
    localparam int ADDR_W   = WORD_AW + 6,
    localparam int LOCAL_AW = WORD_AW + BANK_SLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [1:0]          ctl_bank,
    input  logic [7:0]          ctl_data,
    output logic                ctl_ready,
    input  logic                acc_en,
    input  logic                acc_we,
    input  logic [1:0]          acc_space,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [15:0]         tex_banks,
    output logic [7:0]          aux_banks,
    output logic [3:0]          sec_bg_banks,
    output logic [3:0]          sec_obj_banks,
    output logic [1:0]          aux_status
);
    logic [NUM_BANKS-1:0]                    direct_map;
    logic [BG_SLOTS-1:0][NUM_BANKS-1:0]      bg_map;
    logic [OBJ_SLOTS-1:0][NUM_BANKS-1:0]     obj_map;
    logic [TEX_SLOTS-1:0][NUM_BANKS-1:0]     tex_map;
    logic [AUX_WINDOWS-1:0][NUM_BANKS-1:0]   aux_map;
    logic [NUM_BANKS-1:0]                    sel;
    logic [LOCAL_AW-1:0]                     local_addr;

    vmap_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_bank    (ctl_bank),
        .ctl_data    (ctl_data),
        .ctl_ready   (ctl_ready),
        .direct_map  (direct_map),
        .bg_map      (bg_map),
        .obj_map     (obj_map),
        .tex_map     (tex_map),
        .aux_map     (aux_map),
        .sec_bg_map  (sec_bg_banks),
        .sec_obj_map (sec_obj_banks),
        .aux_status  (aux_status)
    );

    vmap_decode #(.WORD_AW(WORD_AW)) u_dec (
        .acc_space  (acc_space),
        .acc_addr   (acc_addr),
        .direct_map (direct_map),
        .bg_map     (bg_map),
        .obj_map    (obj_map),
        .sel        (sel),
        .local_addr (local_addr)
    );

    vmap_bank_array #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_we     (acc_we),
        .sel        (sel),
        .local_addr (local_addr),
        .wdata      (acc_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    assign tex_banks = tex_map;
    assign aux_banks = aux_map;
endmodule

// File: rtl/vram_bank_router_chk.sv
module vram_bank_router_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic [1:0]        ctl_bank,
    input logic              ctl_ready,
    input logic              acc_en,
    input logic              acc_we,
    input logic [1:0]        acc_space,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [15:0]       tex_banks,
    input logic [7:0]        aux_banks,
    input logic [1:0]        aux_status
);
    // R12: a read request yields rd_valid on the next cycle only
    p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> rd_valid);
    p_no_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_we) |=> !rd_valid);
    // R12: the empty space always reads zero
    p_none_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_space == 2'd3) |=> (rd_data == '0));
    // R3: the gap above the CPU view reads zero
    p_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_space == 2'd0 && acc_addr[ADDR_W-1]) |=> (rd_data == '0));
    // R13: a busy period lasts exactly two cycles
    p_busy_two_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_ready) |=> (!ctl_ready ##1 ctl_ready));
    // R13: without an accepted write the published tables hold
    p_idle_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ready && !ctl_we) |=> ($stable(tex_banks) && $stable(aux_banks) && $stable(aux_status)));
    // R8: a write to bank 2 clears its status bit
    p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_ready && ctl_bank == 2'd2) |=> !aux_status[0]);
    // R7: a status bit rises only together with a window assignment
    p_stat_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_status[1]) |-> (aux_banks[3] || aux_banks[7]));
endmodule

bind vram_bank_router vram_bank_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_bank   (ctl_bank),
    .ctl_ready  (ctl_ready),
    .acc_en     (acc_en),
    .acc_we     (acc_we),
    .acc_space  (acc_space),
    .acc_addr   (acc_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .tex_banks  (tex_banks),
    .aux_banks  (aux_banks),
    .aux_status (aux_status)
);

// File: tb/vram_bank_router_bench.sv
module vram_bank_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int NVEC       = 32;
    localparam logic [1:0] OP_CTL = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    // {op, bank or space, addr, data, expected read, requirement number}
    localparam logic [81:0] VEC [NVEC] = '{
        {OP_CTL, 2'd0, 10'h000, 32'h80, 32'h0, 4'd3},           // R3 bank0 to CPU view
        {OP_WR,  2'd0, 10'h013, 32'hA0A0_0001, 32'h0, 4'd3},
        {OP_RD,  2'd0, 10'h013, 32'h0, 32'hA0A0_0001, 4'd3},     // R3
        {OP_RD,  2'd0, 10'h213, 32'h0, 32'h0, 4'd3},             // R3 gap
        {OP_WR,  2'd0, 10'h213, 32'hDEAD_BEEF, 32'h0, 4'd3},     // R3 gap write dropped
        {OP_RD,  2'd0, 10'h013, 32'h0, 32'hA0A0_0001, 4'd3},     // R3
        {OP_WR,  2'd0, 10'h025, 32'h0F00_0000, 32'h0, 4'd11},
        {OP_CTL, 2'd1, 10'h000, 32'h81, 32'h0, 4'd4},            // R4 bank1 bg slots 0..7
        {OP_WR,  2'd1, 10'h025, 32'h0000_1111, 32'h0, 4'd4},
        {OP_RD,  2'd1, 10'h025, 32'h0, 32'h0000_1111, 4'd4},     // R4
        {OP_RD,  2'd1, 10'h225, 32'h0, 32'h0000_1111, 4'd4},     // R4 mirror
        {OP_RD,  2'd1, 10'h0A5, 32'h0, 32'h0, 4'd12},            // R12 empty slot
        {OP_CTL, 2'd1, 10'h000, 32'h89, 32'h0, 4'd10},           // R10 move to slots 8..15
        {OP_RD,  2'd1, 10'h025, 32'h0, 32'h0, 4'd10},            // R10 old slot empty
        {OP_RD,  2'd1, 10'h0A5, 32'h0, 32'h0000_1111, 4'd10},    // R10
        {OP_CTL, 2'd0, 10'h000, 32'h89, 32'h0, 4'd11},           // R11 overlap
        {OP_RD,  2'd1, 10'h0A5, 32'h0, 32'h0F00_1111, 4'd11},    // R11 OR
        {OP_WR,  2'd1, 10'h0A5, 32'h0000_00F0, 32'h0, 4'd11},    // R11 broadcast
        {OP_CTL, 2'd0, 10'h000, 32'h80, 32'h0, 4'd11},
        {OP_RD,  2'd0, 10'h025, 32'h0, 32'h0000_00F0, 4'd11},    // R11
        {OP_CTL, 2'd1, 10'h000, 32'h82, 32'h0, 4'd5},            // R5 obj slots 0..7
        {OP_RD,  2'd2, 10'h025, 32'h0, 32'h0000_00F0, 4'd5},     // R5
        {OP_RD,  2'd2, 10'h125, 32'h0, 32'h0000_00F0, 4'd5},     // R5 mirror
        {OP_CTL, 2'd1, 10'h000, 32'h9A, 32'h0, 4'd5},            // R5 offset 3 -> slots 8..15
        {OP_RD,  2'd2, 10'h0A5, 32'h0, 32'h0000_00F0, 4'd5},     // R5
        {OP_RD,  2'd2, 10'h025, 32'h0, 32'h0, 4'd10},            // R10
        {OP_RD,  2'd3, 10'h025, 32'h0, 32'h0, 4'd12},            // R12 no space
        {OP_CTL, 2'd0, 10'h000, 32'h00, 32'h0, 4'd2},            // R2 disable
        {OP_RD,  2'd0, 10'h025, 32'h0, 32'h0, 4'd2},             // R2
        {OP_CTL, 2'd2, 10'h000, 32'h80, 32'h0, 4'd3},
        {OP_WR,  2'd0, 10'h125, 32'h1234_5678, 32'h0, 4'd3},
        {OP_RD,  2'd0, 10'h125, 32'h0, 32'h1234_5678, 4'd3}      // R3 bank2 window
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_we = 1'b0;
    logic [1:0]        ctl_bank = '0;
    logic [7:0]        ctl_data = '0;
    logic              ctl_ready;
    logic              acc_en = 1'b0;
    logic              acc_we = 1'b0;
    logic [1:0]        acc_space = '0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [31:0]       acc_wdata = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic [15:0]       tex_banks;
    logic [7:0]        aux_banks;
    logic [3:0]        sec_bg_banks;
    logic [3:0]        sec_obj_banks;
    logic [1:0]        aux_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vram_bank_router u_vram_bank_router (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_bank(ctl_bank), .ctl_data(ctl_data), .ctl_ready(ctl_ready),
        .acc_en(acc_en), .acc_we(acc_we), .acc_space(acc_space), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .tex_banks(tex_banks), .aux_banks(aux_banks), .sec_bg_banks(sec_bg_banks),
        .sec_obj_banks(sec_obj_banks), .aux_status(aux_status)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic ctl_write(input logic [1:0] bank, input logic [7:0] data);
        @(negedge clk);
        ctl_we = 1'b1; ctl_bank = bank; ctl_data = data;
        @(negedge clk);
        ctl_we = 1'b0;
        while (!ctl_ready) @(negedge clk);
    endtask

    task automatic mem_write(input logic [1:0] sp, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_space = sp; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic mem_read(input logic [1:0] sp, input logic [ADDR_W-1:0] a, output logic [31:0] d,
                            output logic v);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_space = sp; acc_addr = a;
        @(negedge clk);
        acc_en = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctl_ready", 32'(ctl_ready), 32'd1);
        check("R1 tex_banks", 32'(tex_banks), 32'd0);
        check("R1 aux_banks", 32'(aux_banks), 32'd0);
        check("R1 sec masks", 32'({sec_bg_banks, sec_obj_banks}), 32'd0);
        check("R1 aux_status", 32'(aux_status), 32'd0);
        check("R1 rd_valid idle", 32'(rd_valid), 32'd0);
        mem_read(2'd1, 10'h013, d, v);
        check("R1 read empty", d, 32'd0);
        check("R12 rd_valid pulse", 32'(v), 32'd1);
        @(negedge clk);
        check("R12 rd_valid drop", 32'(rd_valid), 32'd0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op, sl;
            logic [9:0]  a;
            logic [31:0] dat, ex;
            logic [3:0]  rq;
            {op, sl, a, dat, ex, rq} = VEC[i];
            case (op)
                OP_CTL: ctl_write(sl, dat[7:0]);
                OP_WR:  mem_write(sl, a, dat);
                default: begin
                    mem_read(sl, a, d, v);
                    n_checks++;
                    if (d !== ex || v !== 1'b1) begin
                        n_fail++;
                        $display("FAIL R%0d vector %0d: got %h expected %h", rq, i, d, ex);
                    end
                end
            endcase
        end

        // R6 texture slot
        ctl_write(2'd0, 8'h9B);
        check("R6 tex offset 3", 32'(tex_banks), 32'h1000);
        // R2 bit 2 ignored for bank 0; R10 old texture slot cleared
        ctl_write(2'd0, 8'h87);
        check("R2 bank0 bit2 ignored", 32'(tex_banks), 32'h0001);

        // R7 auxiliary window
        ctl_write(2'd3, 8'h8A);
        check("R7 aux_banks", 32'(aux_banks), 32'h80);
        check("R7 aux_status", 32'(aux_status), 32'h2);

        // R8 same value: status clears, mapping and ready unchanged
        @(negedge clk);
        ctl_we = 1'b1; ctl_bank = 2'd3; ctl_data = 8'h8A;
        @(negedge clk);
        ctl_we = 1'b0;
        check("R13 ready after equal write", 32'(ctl_ready), 32'd1);
        check("R8 status cleared", 32'(aux_status), 32'd0);
        check("R8 aux mapping kept", 32'(aux_banks), 32'h80);

        // R9 second-engine areas
        ctl_write(2'd3, 8'h84);
        check("R9 sec_obj", 32'(sec_obj_banks), 32'h8);
        check("R10 aux cleared", 32'(aux_banks), 32'h0);
        ctl_write(2'd2, 8'h84);
        check("R9 sec_bg", 32'(sec_bg_banks), 32'h4);
        mem_read(2'd0, 10'h125, d, v);
        check("R10 bank2 left CPU view", d, 32'd0);
        ctl_write(2'd2, 8'h85);
        check("R9 target 5 maps nothing", 32'(sec_bg_banks), 32'h0);
        check("R9 target 5 no tex", 32'(tex_banks), 32'h0001);

        // R13 busy timing and ignored write
        @(negedge clk);
        ctl_we = 1'b1; ctl_bank = 2'd1; ctl_data = 8'h83;
        @(negedge clk);
        check("R13 busy cycle 1", 32'(ctl_ready), 32'd0);
        ctl_bank = 2'd0; ctl_data = 8'h00;
        @(negedge clk);
        check("R13 busy cycle 2", 32'(ctl_ready), 32'd0);
        ctl_we = 1'b0;
        @(negedge clk);
        check("R13 ready again", 32'(ctl_ready), 32'd1);
        check("R13 busy write ignored", 32'(tex_banks), 32'h0003);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule